// File: doc/BRIEF.md
# Octal Flash Read Command Sequencer

The sequencer turns simple read requests (a start address plus a byte count) into complete serial flash read transactions on an eight-lane data bus. Each transaction has a fixed order: an optional one- or two-byte command, four address bytes sent most significant first, one mode byte, a programmable run of dummy clocks, and the data phase. Each byte that comes back on the data-in lanes is delivered as a one-cycle valid pulse.

The block tracks whether the attached device is in execute-in-place state, and drops the command bytes on reads where the device already expects an address. Entering or leaving that state is announced by the mode byte and takes effect at the end of a read. The serial clock comes from a reference-clock divider. Its idle level and its behaviour between transactions are configurable. Transfers can use one edge per byte (single rate) or both edges (double rate). A 4-bit select field drives four active-low chip selects, either through a lowest-zero priority decode or directly for an external decoder.

Top module: `oct_rd_seq`

## Requirements
- R1: While reset is held, all chip selects are high, all output enables are low, `idle_o` is 1 and `sclk_o` equals `cpol_i` when `cpha_i` is 1.
- R2: A read of 1 to 2^LEN_W-1 bytes sends, in this order: the command byte, four address bytes with the most significant first, the mode byte, the dummy beats, and then the data beats. The output enables are 8'hFF during the command, address and mode bytes and 0 during dummy and data. Exactly the requested number of bytes is returned, each equal to `dq_i` at its data edge.
- R3: With `dual_op_i` set, the extension byte `opcode_ext_i` follows the command byte directly. It is never sent when the command byte is skipped.
- R4: With `xip_next_i` set, the next read sends the full command and mode byte 8'hA5. Every later read omits the command bytes.
- R5: With `xip_imm_i` set, the very next read omits the command bytes and carries mode byte 8'hA5.
- R6: After both execute-in-place controls are cleared, the next read still omits the command and carries mode byte 8'hFF. The read after it sends the command again.
- R7: With `cs_raw_i` low, the lowest zero bit of `cs_sel_i` selects one chip select: xxx0 gives 1110, xx01 gives 1101, x011 gives 1011, 0111 gives 0111, and 1111 leaves all high.
- R8: With `cs_raw_i` high, `cs_no_o` equals `cs_sel_i` while a transaction is in flight.
- R9: With `cpha_i` 1, `sclk_o` rests at `cpol_i` between transactions. With `cpha_i` 0 and the block enabled, it keeps toggling. In single-rate mode, bytes transfer on the edge that leaves the idle level.
- R10: The serial clock period is 2*(div_i+1) reference clocks.
- R11: With `dtr_i` set, every serial clock edge transfers a byte, and each dummy cycle lasts two beats.
- R12: Clearing `en_i` blocks new requests. An in-flight read ends after the byte being transferred at that time: chip selects go high, output enables go low and no further data is returned.
- R13: `idle_o` is a registered copy of "no transaction in flight". It falls one cycle after the chip select asserts and rises one cycle after the chip select releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 1: clock idle between transactions; 0: free-running |
| dtr_i | input | 1 | Double-rate transfer mode |
| dual_op_i | input | 1 | Send extension command byte |
| div_i | input | DIV_W | Baud divisor |
| opcode_i | input | 8 | Read command byte |
| opcode_ext_i | input | 8 | Extension command byte |
| dummy_i | input | DUMMY_W | Dummy length in serial clock cycles |
| xip_next_i | input | 1 | Enter execute-in-place on next read |
| xip_imm_i | input | 1 | Device already in execute-in-place |
| cs_raw_i | input | 1 | Drive chip selects from the select field directly |
| cs_sel_i | input | NCS | Chip select field |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ADDR_W | Start address |
| req_len_i | input | LEN_W | Byte count |
| rdata_valid_o | output | 1 | Read byte valid pulse |
| rdata_o | output | 8 | Read byte |
| sclk_o | output | 1 | Serial clock |
| cs_no_o | output | NCS | Active-low chip selects |
| dq_o | output | 8 | Data-out lanes |
| dq_oe_o | output | 8 | Data output enables |
| dq_i | input | 8 | Data-in lanes |
| idle_o | output | 1 | Registered idle status |

## Verification
The bench models the flash device. It records each byte at the transferring clock edge and returns a pattern based on the beat index, so a sequencer that misorders address bytes, loses the last data edge or counts double-rate dummy cycles once would deliver visibly wrong data. The execute-in-place sequences look for designs that apply a cleared control at once (they send the command one read too early) and designs that keep sending the extension byte in skip mode. The select patterns include several zeros and the all-ones case, to catch a decode that picks the highest zero or selects a device when none is asked for. A disable in the middle of the data phase checks that the read stops within one byte and does not hang with the chip select low.

// File: rtl/oct_seq_pkg.sv
package oct_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_OP, PH_EXT, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA
  } phase_e;
endpackage

// File: rtl/oct_seq_baud.sv
module oct_seq_baud #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && !clr_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !run_i)     cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/oct_seq_xip.sv
module oct_seq_xip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic want_i,
  input  logic imm_i,
  output logic skip_o,
  output logic keep_o
);
  logic st_q, keep_q;

  assign skip_o = st_q || imm_i;
  assign keep_o = want_i;

  // device state follows the request only once the read carrying the mode byte ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      if (start_i) keep_q <= want_i;
      if (done_i)  st_q   <= keep_q;
    end
  end
endmodule

// File: rtl/oct_seq_cs_dec.sv
module oct_seq_cs_dec #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] sel_i,
  input  logic           raw_i,
  input  logic           act_i,
  output logic [NCS-1:0] cs_no
);
  logic [NCS-1:0] dec;
  logic           found;

  always_comb begin
    dec   = '1;
    found = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (!found && !sel_i[i]) begin
        dec[i] = 1'b0;
        found  = 1'b1;
      end
    end
  end

  assign cs_no = !act_i ? '1 : (raw_i ? sel_i : dec);
endmodule

// File: rtl/oct_rd_seq.sv
module oct_rd_seq
  import oct_seq_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LEN_W      = 12,
  parameter int          DUMMY_W    = 5,
  parameter int          DIV_W      = 4,
  parameter int          NCS        = 4,
  parameter logic [7:0]  MODE_KEEP  = 8'hA5,
  parameter logic [7:0]  MODE_LEAVE = 8'hFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               dtr_i,
  input  logic               dual_op_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [7:0]         opcode_i,
  input  logic [7:0]         opcode_ext_i,
  input  logic [DUMMY_W-1:0] dummy_i,
  input  logic               xip_next_i,
  input  logic               xip_imm_i,
  input  logic               cs_raw_i,
  input  logic [NCS-1:0]     cs_sel_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  output logic               rdata_valid_o,
  output logic [7:0]         rdata_o,
  output logic               sclk_o,
  output logic [NCS-1:0]     cs_no_o,
  output logic [7:0]         dq_o,
  output logic [7:0]         dq_oe_o,
  input  logic [7:0]         dq_i,
  output logic               idle_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AIDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CNT_W      = (LEN_W > DUMMY_W + 1) ? LEN_W : DUMMY_W + 1;

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [DUMMY_W:0]   dum_q;
  logic [7:0]         mode_q, rd_q, abyte;
  logic               dual_q, dtr_q, act_q, rv_q, idle_q;
  logic               busy, acc, run, tick, beat, last, done, drv;
  logic               xip_skip, xip_keep;

  assign busy        = (ph_q != PH_IDLE);
  assign req_ready_o = en_i && !busy;
  assign acc         = req_valid_i && req_ready_o;
  assign run         = busy || (en_i && !cpha_i);
  assign beat        = busy && tick && (dtr_q || !act_q);
  assign last        = (ph_q == PH_DATA) && (cnt_q == CNT_W'(len_q - 1'b1));
  assign done        = beat && (last || !en_i);

  oct_seq_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (acc),
    .div_i  (div_i),
    .tick_o (tick)
  );

  oct_seq_xip u_xip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc),
    .done_i  (done),
    .want_i  (xip_next_i || xip_imm_i),
    .imm_i   (xip_imm_i),
    .skip_o  (xip_skip),
    .keep_o  (xip_keep)
  );

  oct_seq_cs_dec #(.NCS(NCS)) u_cs (
    .sel_i (cs_sel_i),
    .raw_i (cs_raw_i),
    .act_i (busy),
    .cs_no (cs_no_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      dum_q  <= '0;
      mode_q <= '0;
      dual_q <= 1'b0;
      dtr_q  <= 1'b0;
      act_q  <= 1'b0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
      idle_q <= 1'b1;
    end else begin
      idle_q <= !busy;
      rv_q   <= 1'b0;
      if (acc) begin
        ph_q   <= xip_skip ? PH_ADDR : PH_OP;
        cnt_q  <= '0;
        addr_q <= req_addr_i;
        len_q  <= req_len_i;
        dum_q  <= dtr_i ? {dummy_i, 1'b0} : {1'b0, dummy_i};
        mode_q <= xip_keep ? MODE_KEEP : MODE_LEAVE;
        dual_q <= dual_op_i;
        dtr_q  <= dtr_i;
        act_q  <= 1'b0;
      end else begin
        if (tick)      act_q <= !act_q;
        else if (!run) act_q <= 1'b0;
        if (beat) begin
          cnt_q <= cnt_q + 1'b1;
          if (ph_q == PH_DATA) begin
            rv_q <= 1'b1;
            rd_q <= dq_i;
          end
          if (!en_i) begin
            ph_q <= PH_IDLE;   // stop after the byte now on the wire
          end else begin
            unique case (ph_q)
              PH_OP: begin
                ph_q  <= dual_q ? PH_EXT : PH_ADDR;
                cnt_q <= '0;
              end
              PH_EXT: begin
                ph_q  <= PH_ADDR;
                cnt_q <= '0;
              end
              PH_ADDR: if (cnt_q == CNT_W'(ADDR_BYTES - 1)) begin
                ph_q  <= PH_MODE;
                cnt_q <= '0;
              end
              PH_MODE: begin
                ph_q  <= (dum_q == '0) ? PH_DATA : PH_DUMMY;
                cnt_q <= '0;
              end
              PH_DUMMY: if (cnt_q == CNT_W'(dum_q - 1'b1)) begin
                ph_q  <= PH_DATA;
                cnt_q <= '0;
              end
              PH_DATA: if (last) ph_q <= PH_IDLE;
              default: ph_q <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    abyte = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (cnt_q[AIDX_W-1:0] == AIDX_W'(ADDR_BYTES - 1 - b)) abyte = addr_q[b*8 +: 8];
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_OP:   dq_o = opcode_i;
      PH_EXT:  dq_o = opcode_ext_i;
      PH_ADDR: dq_o = abyte;
      PH_MODE: dq_o = mode_q;
      default: dq_o = '0;
    endcase
  end

  assign drv           = (ph_q == PH_OP) || (ph_q == PH_EXT) || (ph_q == PH_ADDR) || (ph_q == PH_MODE);
  assign dq_oe_o       = {8{drv}};
  assign sclk_o        = cpol_i ^ act_q;
  assign rdata_valid_o = rv_q;
  assign rdata_o       = rd_q;
  assign idle_o        = idle_q;
endmodule

// File: rtl/oct_rd_seq_chk.sv
module oct_rd_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           cpol_i,
  input logic           cpha_i,
  input logic           cs_raw_i,
  input logic [NCS-1:0] cs_no_o,
  input logic [7:0]     dq_oe_o,
  input logic           req_ready_o,
  input logic           rdata_valid_o,
  input logic           idle_o,
  input logic           sclk_o
);
  p_cs_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_raw_i |-> ($countones(~cs_no_o) <= 1));

  p_rdata_undriven_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> (dq_oe_o == 8'h00));

  p_idle_lag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no_o != '1) |=> !idle_o);

  p_ready_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !req_ready_o);

  p_sclk_rest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && $past(cpha_i)) |-> (sclk_o == cpol_i));
endmodule

bind oct_rd_seq oct_rd_seq_chk #(.NCS(NCS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .cpol_i        (cpol_i),
  .cpha_i        (cpha_i),
  .cs_raw_i      (cs_raw_i),
  .cs_no_o       (cs_no_o),
  .dq_oe_o       (dq_oe_o),
  .req_ready_o   (req_ready_o),
  .rdata_valid_o (rdata_valid_o),
  .idle_o        (idle_o),
  .sclk_o        (sclk_o)
);

// File: tb/oct_rd_seq_tb_top.sv
`timescale 1ns/1ps
module oct_rd_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, cpol = 1'b0, cpha = 1'b1, dtr = 1'b0, dual = 1'b0;
  logic [3:0] div = 4'd0;
  logic [7:0] op_c = 8'h9C, ext_c = 8'h63;
  logic [4:0] dummy = 5'd3;
  logic xnext = 1'b0, ximm = 1'b0, raw = 1'b0;
  logic [3:0] sel = 4'b1110;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic req_ready, rvalid, sclk, idle;
  logic [7:0] rdata, dq_o, dq_oe, dq_in = '0;
  logic [3:0] cs_n;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] rec [64];
  logic [7:0] rec_oe [64];
  logic [7:0] rd [64];
  int beat_n = 0, rd_n = 0;
  logic p_cs = 1'b0, p_sclk = 1'b0;
  logic [7:0] p_dq = '0, p_oe = '0;
  logic [3:0] cs_seen;

  always #5 clk = ~clk;

  oct_rd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .dtr_i(dtr), .dual_op_i(dual), .div_i(div), .opcode_i(op_c),
    .opcode_ext_i(ext_c), .dummy_i(dummy), .xip_next_i(xnext), .xip_imm_i(ximm),
    .cs_raw_i(raw), .cs_sel_i(sel), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .rdata_valid_o(rvalid),
    .rdata_o(rdata), .sclk_o(sclk), .cs_no_o(cs_n), .dq_o(dq_o), .dq_oe_o(dq_oe),
    .dq_i(dq_in), .idle_o(idle)
  );

  function automatic logic [7:0] pat(int n);
    return 8'(n * 37 + 60);
  endfunction

  function automatic logic [3:0] cs_exp(logic [3:0] s);
    casez (s)
      4'b???0: return 4'b1110;
      4'b??01: return 4'b1101;
      4'b?011: return 4'b1011;
      4'b0111: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // flash model: byte on the wire before each transferring edge is recorded
  always @(negedge clk) begin
    logic cs_act;
    cs_act = (cs_n != 4'hF);
    if (!p_cs && cs_act) begin
      beat_n = 0;
      dq_in  = pat(0);
    end else if (p_cs && (sclk != p_sclk) && (dtr || p_sclk == cpol)) begin
      if (beat_n < 64) begin
        rec[beat_n]    = p_dq;
        rec_oe[beat_n] = p_oe;
      end
      beat_n++;
      dq_in = pat(beat_n);
    end
    if (rvalid) begin
      if (rd_n < 64) rd[rd_n] = rdata;
      rd_n++;
    end
    p_cs = cs_act; p_sclk = sclk; p_dq = dq_o; p_oe = dq_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_read(input logic [31:0] a, input int n, input bit lag);
    int w;
    @(negedge clk);
    chk(req_ready, "R12 ready when enabled", req_ready, 1);
    rd_n = 0;
    req_addr = a; req_len = 12'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cs_seen = cs_n;
    if (lag) chk(idle == 1'b1 && cs_n != 4'hF, "R13 idle lags start", idle, 1);
    @(negedge clk);
    if (lag) chk(idle == 1'b0, "R13 idle low in flight", idle, 0);
    w = 0;
    while (!idle && w < 5000) begin @(negedge clk); w++; end
    chk(w < 5000, "R2 read completes", w, 5000);
    if (lag) chk(cs_n == 4'hF, "R13 cs released before idle", cs_n, 4'hF);
    @(negedge clk);
  endtask

  task automatic chk_frame(input string rq, input bit has_op, input bit has_ext,
                           input logic [7:0] md, input int dbeats, input logic [31:0] a, input int n);
    int i;
    i = 0;
    if (has_op) begin
      chk(rec[i] == op_c && rec_oe[i] == 8'hFF, {rq, " opcode"}, rec[i], op_c); i++;
    end
    if (has_ext) begin
      chk(rec[i] == ext_c && rec_oe[i] == 8'hFF, {rq, " ext byte"}, rec[i], ext_c); i++;
    end
    if (!has_op) chk(rec[0] == a[31:24], {rq, " no opcode"}, rec[0], a[31:24]);
    for (int b = 0; b < 4; b++) begin
      chk(rec[i] == a[31-8*b -: 8] && rec_oe[i] == 8'hFF, {rq, " addr byte"}, rec[i], a[31-8*b -: 8]);
      i++;
    end
    chk(rec[i] == md, {rq, " mode byte"}, rec[i], md); i++;
    for (int d = 0; d < dbeats; d++) begin
      chk(rec_oe[i] == 8'h00, {rq, " dummy undriven"}, rec_oe[i], 0); i++;
    end
    for (int j = 0; j < n; j++) begin
      chk(rd[j] == pat(i) && rec_oe[i] == 8'h00, {rq, " data"}, rd[j], pat(i)); i++;
    end
    chk(beat_n == i, {rq, " beat count"}, beat_n, i);
    chk(rd_n == n, {rq, " byte count"}, rd_n, n);
  endtask

  task automatic t_reset();
    #23;
    chk(cs_n == 4'hF, "R1 cs high in reset", cs_n, 4'hF);
    chk(dq_oe == 8'h00, "R1 oe low in reset", dq_oe, 0);
    chk(idle == 1'b1, "R1 idle in reset", idle, 1);
    chk(sclk == cpol, "R1 sclk idle in reset", sclk, cpol);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    do_read(32'h12345678, 4, 1'b1);
    chk_frame("R2 sdr", 1, 0, 8'hFF, 3, 32'h12345678, 4);
    div = 4'd2; dummy = 5'd0;
    do_read(32'hA0B1C2D3, 7, 1'b1);
    chk_frame("R2 div2 nodummy", 1, 0, 8'hFF, 0, 32'hA0B1C2D3, 7);
    div = 4'd0; dummy = 5'd3;
  endtask

  task automatic t_dual();
    dual = 1'b1;
    do_read(32'h00FF00FF, 3, 1'b1);
    chk_frame("R3 dual opcode", 1, 1, 8'hFF, 3, 32'h00FF00FF, 3);
  endtask

  task automatic t_xip();
    xnext = 1'b1;
    do_read(32'h11110000, 2, 1'b1);
    chk_frame("R4 enter read", 1, 1, 8'hA5, 3, 32'h11110000, 2);
    do_read(32'h22220000, 2, 1'b1);
    chk_frame("R4 skip opcode and ext", 0, 0, 8'hA5, 3, 32'h22220000, 2);
    xnext = 1'b0;
    do_read(32'h33330000, 2, 1'b1);
    chk_frame("R6 exit deferred", 0, 0, 8'hFF, 3, 32'h33330000, 2);
    do_read(32'h44440000, 2, 1'b1);
    chk_frame("R6 opcode back", 1, 1, 8'hFF, 3, 32'h44440000, 2);
    dual = 1'b0;
    ximm = 1'b1;
    do_read(32'h55550000, 2, 1'b1);
    chk_frame("R5 immediate skip", 0, 0, 8'hA5, 3, 32'h55550000, 2);
    ximm = 1'b0;
    do_read(32'h66660000, 2, 1'b1);
    chk_frame("R6 imm exit deferred", 0, 0, 8'hFF, 3, 32'h66660000, 2);
    do_read(32'h77770000, 2, 1'b1);
    chk_frame("R6 imm opcode back", 1, 0, 8'hFF, 3, 32'h77770000, 2);
  endtask

  task automatic cs_case(input logic [3:0] s, input logic r);
    sel = s; raw = r;
    do_read(32'h0, 1, 1'b0);
    if (r) chk(cs_seen == s, "R8 raw select", cs_seen, s);
    else   chk(cs_seen == cs_exp(s), "R7 priority select", cs_seen, cs_exp(s));
  endtask

  task automatic t_cs();
    cs_case(4'b1010, 1'b0);
    cs_case(4'b0101, 1'b0);
    cs_case(4'b0011, 1'b0);
    cs_case(4'b0111, 1'b0);
    cs_case(4'b1111, 1'b0);
    cs_case(4'b1010, 1'b1);
    cs_case(4'b0000, 1'b1);
    sel = 4'b1110; raw = 1'b0;
  endtask

  task automatic t_dtr();
    dtr = 1'b1; dummy = 5'd2;
    do_read(32'hCAFE0123, 5, 1'b1);
    chk_frame("R11 double rate", 1, 0, 8'hFF, 4, 32'hCAFE0123, 5);
    div = 4'd1;
    do_read(32'h0BADF00D, 3, 1'b1);
    chk_frame("R11 double rate div1", 1, 0, 8'hFF, 4, 32'h0BADF00D, 3);
    dtr = 1'b0; dummy = 5'd3; div = 4'd0;
  endtask

  task automatic measure(output int per);
    int w;
    w = 0;
    @(negedge clk);
    while (sclk != 1'b0 && w < 200) begin @(negedge clk); w++; end
    while (sclk != 1'b1 && w < 200) begin @(negedge clk); w++; end
    per = 0;
    while (sclk != 1'b0 && w < 200) begin @(negedge clk); w++; per++; end
    while (sclk != 1'b1 && w < 200) begin @(negedge clk); w++; per++; end
  endtask

  task automatic t_clock();
    int per;
    bit ok;
    cpha = 1'b0; div = 4'd3;
    repeat (40) @(negedge clk);
    measure(per);
    chk(per == 8, "R10 period div3", per, 8);
    chk(per != 0, "R9 free-running clock", per, 8);
    div = 4'd0;
    repeat (40) @(negedge clk);
    measure(per);
    chk(per == 2, "R10 period div0", per, 2);
    cpha = 1'b1; cpol = 1'b1;
    repeat (3) @(negedge clk);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (sclk != 1'b1) ok = 1'b0; end
    chk(ok, "R9 clock rests high", sclk, 1);
    do_read(32'hF00D1234, 3, 1'b1);
    chk_frame("R9 read with high idle", 1, 0, 8'hFF, 3, 32'hF00D1234, 3);
    cpol = 1'b0;
    repeat (3) @(negedge clk);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (sclk != 1'b0) ok = 1'b0; end
    chk(ok, "R9 clock rests low", sclk, 0);
  endtask

  task automatic t_disable();
    int w, k;
    div = 4'd1; dummy = 5'd0;
    @(negedge clk);
    rd_n = 0;
    req_addr = 32'h01020304; req_len = 12'd30; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (rd_n < 3 && w < 2000) begin @(negedge clk); w++; end
    en = 1'b0;
    k = rd_n;
    w = 0;
    while (!idle && w < 200) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF, "R12 cs released", cs_n, 4'hF);
    chk(dq_oe == 8'h00, "R12 pins inputs", dq_oe, 0);
    chk(req_ready == 1'b0, "R12 no accept when disabled", req_ready, 0);
    chk(rd_n <= k + 1, "R12 one byte after disable", rd_n, k + 1);
    chk(rd_n < 30, "R12 read cut short", rd_n, 30);
    en = 1'b1; div = 4'd0; dummy = 5'd3;
    repeat (3) @(negedge clk);
    do_read(32'h89ABCDEF, 2, 1'b1);
    chk_frame("R12 read after re-enable", 1, 0, 8'hFF, 3, 32'h89ABCDEF, 2);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_basic();
    t_dual();
    t_xip();
    t_cs();
    t_dtr();
    t_clock();
    t_disable();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule